// File: doc/BRIEF.md
# Menu-Indexed SPI Flash Cycle Sequencer

This block is a register-mapped controller that runs one serial flash cycle at a time on a single-lane SPI master port (mode 0: clock idles low, data sampled on the rising edge, changed on the falling edge). Software never sends raw opcodes. It fills an eight-entry opcode menu and a 2-bit type per entry, sets a 24-bit flash address, and loads a 64-byte data buffer for writes. It then writes a control word that names a menu entry, an optional data byte count and a go bit. The 2-bit type of the chosen entry decides whether an address phase follows the opcode and whether the data phase sends or receives.

An optional atomic mode sends one of two prefix opcodes as a separate chip-select frame ahead of the main opcode. A lock bit freezes the menu and the type register until reset. A programmable base limit rejects address-carrying cycles that point below it. Progress and outcome are reported through a busy bit and two sticky flags, done and error.

The register port is a word-addressed write strobe with a combinational read path. Word addresses: 0 status, 1 control, 2 flash address, 3 type register, 4 menu entries 0 to 3 (entry n in byte n), 5 menu entries 4 to 7 (entry 4+n in byte n), 6 prefix opcodes, 7 base limit, 16 to 31 data buffer words 0 to 15.

Top module: `opseq_flash_ctrl`

## Requirements
- R1: After reset the status word reads 0, the control word reads 0, chip select is high and the SPI clock is low.
- R2: Status bit 0 (busy) reads 1 from the clock edge that accepts a go write until the cycle ends; it clears on the same edge that sets the done flag.
- R3: Status bit 2 (done) and bit 3 (error) are sticky; writing 1 to a bit clears it, writing 0 leaves it unchanged.
- R4: A go write while busy sets the error flag and starts no new frame; the running cycle completes untouched.
- R5: Control word: bit 1 go, bits 6:4 menu index, bit 14 data phase present, bits 13:8 data byte count minus one (1 to 64 bytes). The first byte of the frame is the selected menu entry; without bit 14 there is no data phase.
- R6: The type register holds entry n in bits 2n+1:2n; type 00 is read without address, 01 write without address, 10 read with address, 11 write with address.
- R7: For address types, the low 24 bits of the address register follow the opcode as three bytes, most significant first; every byte is sent most significant bit first.
- R8: Data buffer word k holds bytes 4k to 4k+3 with byte 4k in bits 7:0. A write cycle sends buffer bytes from byte 0 upward; a read cycle sends 0x00 and stores received bytes into the buffer from byte 0 upward.
- R9: Control bit 2 requests an atomic cycle: the prefix opcode picked by control bit 3 (prefix register bits 7:0 for 0, bits 15:8 for 1) is sent alone in its own frame, chip select stays high for at least one SPI clock period, then the main frame follows.
- R10: Writing 1 to status bit 15 sets the lock, which reads back on bit 15 and holds until reset; while locked, writes to the menu words and the type register are ignored.
- R11: A go write for an address type whose address is below the 24-bit base limit (word 7) sets the error flag, leaves busy at 0 and produces no SPI activity; an address equal to the limit, or a type without address, is accepted.
- R12: Chip select is low only while a cycle is in progress, and the SPI clock stays low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A register write lands on the next rising edge and reads are combinational, so the bench drives writes on falling edges and reads one falling edge later, which is where busy and the error flag first show a go write's outcome. Each SPI byte takes sixteen times the clock divider in clock cycles and a frame takes its byte count times that plus a few sequencing cycles, so the bench never times frames by cycle count: it polls busy until it clears and then compares the bytes a mode-0 slave model captured, the buffer contents and the status word. The chip-select gap of an atomic cycle is measured in clock cycles at the port and must be at least two divider periods.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

    localparam int MENU_N      = 8;
    localparam int MENU_IDX_W  = 3;
    localparam int FL_ADDR_W   = 24;
    localparam int ADDR_BYTES  = FL_ADDR_W / 8;
    localparam int REG_AW      = 5;

    localparam logic [REG_AW-1:0] RA_STATUS  = 5'd0;
    localparam logic [REG_AW-1:0] RA_CTRL    = 5'd1;
    localparam logic [REG_AW-1:0] RA_ADDR    = 5'd2;
    localparam logic [REG_AW-1:0] RA_OPTYPE  = 5'd3;
    localparam logic [REG_AW-1:0] RA_MENU_LO = 5'd4;
    localparam logic [REG_AW-1:0] RA_MENU_HI = 5'd5;
    localparam logic [REG_AW-1:0] RA_PREFIX  = 5'd6;
    localparam logic [REG_AW-1:0] RA_BASE    = 5'd7;

    localparam int SB_BUSY = 0;
    localparam int SB_DONE = 2;
    localparam int SB_ERR  = 3;
    localparam int SB_LOCK = 15;

    localparam int CB_GO   = 1;
    localparam int CB_ATOM = 2;
    localparam int CB_PSEL = 3;
    localparam int CB_IDX  = 4;
    localparam int CB_CNT  = 8;
    localparam int CB_DATA = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_GAP,
        ST_OPC,
        ST_ALOAD,
        ST_ADDR,
        ST_DLOAD,
        ST_DATA
    } seq_state_e;

endpackage

// File: rtl/opseq_shifter.sv
module opseq_shifter #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic             active;
        logic             sck;
        logic [DIV_W-1:0] div_cnt;
        logic [2:0]       bit_cnt;
        logic [7:0]       sr;
        logic [7:0]       rx;
        logic             done;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (start_i) begin
            d.active  = 1'b1;
            d.sck     = 1'b0;
            d.div_cnt = '0;
            d.bit_cnt = '0;
            d.sr      = tx_i;
        end else if (q.active) begin
            if (q.div_cnt == DIV_W'(CLK_DIV - 1)) begin
                d.div_cnt = '0;
                if (!q.sck) begin
                    d.sck = 1'b1;
                    d.rx  = {q.rx[6:0], miso_i};
                end else begin
                    d.sck = 1'b0;
                    if (q.bit_cnt == 3'd7) begin
                        d.active = 1'b0;
                        d.done   = 1'b1;
                    end else begin
                        d.bit_cnt = q.bit_cnt + 3'd1;
                        d.sr      = {q.sr[6:0], 1'b0};
                    end
                end
            end else begin
                d.div_cnt = q.div_cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck_o  = q.sck;
    assign mosi_o = q.sr[7];
    assign done_o = q.done;
    assign rx_o   = q.rx;

    // R12: a new byte is only launched when the engine is idle
    a_r12_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !q.active);
    // R12: the serial clock rests low between bytes
    a_r12_sck_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !q.active |-> !q.sck);

endmodule

// File: rtl/opseq_seq.sv
module opseq_seq
    import opseq_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int CNT_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 atomic_i,
    input  logic [7:0]           prefix_op_i,
    input  logic [7:0]           main_op_i,
    input  logic [1:0]           optype_i,
    input  logic [FL_ADDR_W-1:0] addr_i,
    input  logic                 has_data_i,
    input  logic [CNT_W-1:0]     last_idx_i,
    input  logic [7:0]           buf_byte_i,
    input  logic                 byte_done_i,
    input  logic [7:0]           rx_byte_i,
    output logic                 cs_n_o,
    output logic                 shift_start_o,
    output logic [7:0]           shift_tx_o,
    output logic [CNT_W-1:0]     buf_idx_o,
    output logic                 buf_we_o,
    output logic [7:0]           buf_wbyte_o,
    output logic                 cyc_done_o
);
    localparam int GAP_LAST = 2 * CLK_DIV - 1;
    localparam int GAP_W    = $clog2(2 * CLK_DIV);

    typedef struct packed {
        seq_state_e           state;
        logic                 cs_n;
        logic                 shift;
        logic [7:0]           tx;
        logic [CNT_W-1:0]     idx;
        logic [GAP_W-1:0]     gap;
        logic                 done;
        logic [7:0]           main_op;
        logic                 has_addr;
        logic                 is_write;
        logic                 has_data;
        logic [CNT_W-1:0]     last;
        logic [FL_ADDR_W-1:0] addr;
    } seq_t;

    seq_t q, d;
    logic fin;

    always_comb begin
        d = q;
        d.shift = 1'b0;
        d.done  = 1'b0;
        fin     = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.main_op  = main_op_i;
                    d.has_addr = optype_i[1];
                    d.is_write = optype_i[0];
                    d.has_data = has_data_i;
                    d.last     = last_idx_i;
                    d.addr     = addr_i;
                    d.cs_n     = 1'b0;
                    d.shift    = 1'b1;
                    if (atomic_i) begin
                        d.tx    = prefix_op_i;
                        d.state = ST_PRE;
                    end else begin
                        d.tx    = main_op_i;
                        d.state = ST_OPC;
                    end
                end
            end
            ST_PRE: begin
                if (byte_done_i) begin
                    d.cs_n  = 1'b1;
                    d.gap   = '0;
                    d.state = ST_GAP;
                end
            end
            ST_GAP: begin
                if (q.gap == GAP_W'(GAP_LAST)) begin
                    d.cs_n  = 1'b0;
                    d.shift = 1'b1;
                    d.tx    = q.main_op;
                    d.state = ST_OPC;
                end else begin
                    d.gap = q.gap + GAP_W'(1);
                end
            end
            ST_OPC: begin
                if (byte_done_i) begin
                    d.idx = '0;
                    if (q.has_addr)      d.state = ST_ALOAD;
                    else if (q.has_data) d.state = ST_DLOAD;
                    else                 fin = 1'b1;
                end
            end
            ST_ALOAD: begin
                d.shift = 1'b1;
                d.tx    = q.addr[8*(ADDR_BYTES-1-int'(q.idx)) +: 8];
                d.state = ST_ADDR;
            end
            ST_ADDR: begin
                if (byte_done_i) begin
                    if (q.idx == CNT_W'(ADDR_BYTES - 1)) begin
                        d.idx = '0;
                        if (q.has_data) d.state = ST_DLOAD;
                        else            fin = 1'b1;
                    end else begin
                        d.idx   = q.idx + CNT_W'(1);
                        d.state = ST_ALOAD;
                    end
                end
            end
            ST_DLOAD: begin
                d.shift = 1'b1;
                d.tx    = q.is_write ? buf_byte_i : 8'h00;
                d.state = ST_DATA;
            end
            ST_DATA: begin
                if (byte_done_i) begin
                    if (q.idx == q.last) begin
                        fin = 1'b1;
                    end else begin
                        d.idx   = q.idx + CNT_W'(1);
                        d.state = ST_DLOAD;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (fin) begin
            d.cs_n  = 1'b1;
            d.done  = 1'b1;
            d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n_o        = q.cs_n;
    assign shift_start_o = q.shift;
    assign shift_tx_o    = q.tx;
    assign buf_idx_o     = q.idx;
    assign buf_we_o      = (q.state == ST_DATA) && byte_done_i && !q.is_write;
    assign buf_wbyte_o   = rx_byte_i;
    assign cyc_done_o    = q.done;

    // R12: a byte finishes only while the sequencer is waiting for one
    a_r12_done_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_i |-> (q.state inside {ST_PRE, ST_OPC, ST_ADDR, ST_DATA}));
    // R9: every byte launch happens with chip select asserted
    a_r9_cs_low_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        q.shift |-> !q.cs_n);

endmodule

// File: rtl/opseq_flash_ctrl.sv
module opseq_flash_ctrl
    import opseq_pkg::*;
#(
    parameter int CLK_DIV   = 2,
    parameter int BUF_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int CNT_W     = $clog2(BUF_BYTES);
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int WSEL_W    = $clog2(BUF_WORDS);

    typedef struct packed {
        logic                         busy;
        logic                         done;
        logic                         err;
        logic                         lock;
        logic                         atomic;
        logic                         pre_sel;
        logic [MENU_IDX_W-1:0]        idx;
        logic [CNT_W-1:0]             cnt;
        logic                         has_data;
        logic [FL_ADDR_W-1:0]         addr;
        logic [FL_ADDR_W-1:0]         base;
        logic [2*MENU_N-1:0]          optype;
        logic [MENU_N-1:0][7:0]       menu;
        logic [1:0][7:0]              prefix;
        logic [BUF_BYTES-1:0][7:0]    dbuf;
    } regs_t;

    regs_t q, d;

    logic                  go, reject, accept;
    logic [MENU_IDX_W-1:0] widx;
    logic [1:0]            wtype;
    logic                  seq_cs_n, seq_shift, seq_bwe, seq_done;
    logic [7:0]            seq_tx, seq_wbyte, shf_rx;
    logic [CNT_W-1:0]      seq_bidx;
    logic                  shf_done;

    assign widx   = reg_wdata[CB_IDX +: MENU_IDX_W];
    assign wtype  = q.optype[{widx, 1'b0} +: 2];
    assign go     = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CB_GO];
    assign reject = wtype[1] && (q.addr < q.base);
    assign accept = go && !q.busy && !reject;

    always_comb begin
        d = q;
        if (reg_we) begin
            if (reg_addr[REG_AW-1]) begin
                for (int k = 0; k < 4; k++) begin
                    d.dbuf[4*int'(reg_addr[WSEL_W-1:0]) + k] = reg_wdata[8*k +: 8];
                end
            end else begin
                case (reg_addr)
                    RA_STATUS: begin
                        if (reg_wdata[SB_DONE]) d.done = 1'b0;
                        if (reg_wdata[SB_ERR])  d.err  = 1'b0;
                        if (reg_wdata[SB_LOCK]) d.lock = 1'b1;
                    end
                    RA_CTRL: begin
                        d.atomic   = reg_wdata[CB_ATOM];
                        d.pre_sel  = reg_wdata[CB_PSEL];
                        d.idx      = widx;
                        d.cnt      = reg_wdata[CB_CNT +: CNT_W];
                        d.has_data = reg_wdata[CB_DATA];
                    end
                    RA_ADDR:   d.addr = reg_wdata[FL_ADDR_W-1:0];
                    RA_OPTYPE: if (!q.lock) d.optype = reg_wdata[2*MENU_N-1:0];
                    RA_MENU_LO: if (!q.lock) begin
                        for (int k = 0; k < 4; k++) d.menu[k] = reg_wdata[8*k +: 8];
                    end
                    RA_MENU_HI: if (!q.lock) begin
                        for (int k = 0; k < 4; k++) d.menu[4+k] = reg_wdata[8*k +: 8];
                    end
                    RA_PREFIX: d.prefix = reg_wdata[15:0];
                    RA_BASE:   d.base   = reg_wdata[FL_ADDR_W-1:0];
                    default: ;
                endcase
            end
        end
        if (go) begin
            if (q.busy || reject) d.err  = 1'b1;
            else                  d.busy = 1'b1;
        end
        if (seq_bwe) d.dbuf[seq_bidx] = seq_wbyte;
        if (seq_done) begin
            d.busy = 1'b0;
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[REG_AW-1]) begin
            for (int k = 0; k < 4; k++) begin
                reg_rdata[8*k +: 8] = q.dbuf[4*int'(reg_addr[WSEL_W-1:0]) + k];
            end
        end else begin
            case (reg_addr)
                RA_STATUS: begin
                    reg_rdata[SB_BUSY] = q.busy;
                    reg_rdata[SB_DONE] = q.done;
                    reg_rdata[SB_ERR]  = q.err;
                    reg_rdata[SB_LOCK] = q.lock;
                end
                RA_CTRL: begin
                    reg_rdata[CB_ATOM]               = q.atomic;
                    reg_rdata[CB_PSEL]               = q.pre_sel;
                    reg_rdata[CB_IDX +: MENU_IDX_W]  = q.idx;
                    reg_rdata[CB_CNT +: CNT_W]       = q.cnt;
                    reg_rdata[CB_DATA]               = q.has_data;
                end
                RA_ADDR:    reg_rdata[FL_ADDR_W-1:0] = q.addr;
                RA_OPTYPE:  reg_rdata[2*MENU_N-1:0]  = q.optype;
                RA_MENU_LO: reg_rdata = {q.menu[3], q.menu[2], q.menu[1], q.menu[0]};
                RA_MENU_HI: reg_rdata = {q.menu[7], q.menu[6], q.menu[5], q.menu[4]};
                RA_PREFIX:  reg_rdata[15:0] = q.prefix;
                RA_BASE:    reg_rdata[FL_ADDR_W-1:0] = q.base;
                default: ;
            endcase
        end
    end

    opseq_seq #(
        .CLK_DIV (CLK_DIV),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (accept),
        .atomic_i      (reg_wdata[CB_ATOM]),
        .prefix_op_i   (q.prefix[reg_wdata[CB_PSEL]]),
        .main_op_i     (q.menu[widx]),
        .optype_i      (wtype),
        .addr_i        (q.addr),
        .has_data_i    (reg_wdata[CB_DATA]),
        .last_idx_i    (reg_wdata[CB_CNT +: CNT_W]),
        .buf_byte_i    (q.dbuf[seq_bidx]),
        .byte_done_i   (shf_done),
        .rx_byte_i     (shf_rx),
        .cs_n_o        (seq_cs_n),
        .shift_start_o (seq_shift),
        .shift_tx_o    (seq_tx),
        .buf_idx_o     (seq_bidx),
        .buf_we_o      (seq_bwe),
        .buf_wbyte_o   (seq_wbyte),
        .cyc_done_o    (seq_done)
    );

    opseq_shifter #(
        .CLK_DIV (CLK_DIV)
    ) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (seq_shift),
        .tx_i    (seq_tx),
        .miso_i  (spi_miso),
        .sck_o   (spi_sck),
        .mosi_o  (spi_mosi),
        .done_o  (shf_done),
        .rx_o    (shf_rx)
    );

    assign spi_cs_n = seq_cs_n;

    // R2: cycle end clears busy and raises done on one edge
    a_r2_end_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (!q.busy && q.done));
    // R4: go while busy raises the error flag
    a_r4_go_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
        (go && q.busy) |=> q.err);
    // R10: the lock never drops once set
    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.lock |=> q.lock);
    // R10: menu and type register frozen under lock
    a_r10_menu_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        q.lock |=> ($stable(q.menu) && $stable(q.optype)));
    // R11: a rejected go leaves the port quiet
    a_r11_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !q.busy && reject) |=> (spi_cs_n && !q.busy));
    // R12: chip select only low while a cycle runs
    a_r12_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> spi_cs_n);
    // R12: clock low whenever chip select is high
    a_r12_sck_low_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

endmodule

// File: tb/opseq_flash_ctrl_bench.sv
`timescale 1ns/1ps
module opseq_flash_ctrl_bench;
    localparam int CLK_DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    opseq_flash_ctrl #(.CLK_DIV(CLK_DIV), .BUF_BYTES(64)) u_opseq_flash_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- mode-0 slave model with frame log ----------------
    logic [7:0] seg_log [0:63][0:79];
    int         seg_len [0:63];
    int         seg_cnt = 0;
    int         bitpos  = 0;
    logic [7:0] sh = '0;

    function automatic logic [7:0] resp(int k);
        return 8'((k * 29 + 167) & 255);
    endfunction

    always @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            if (bitpos > 0) begin
                seg_len[seg_cnt % 64] = bitpos / 8;
                seg_cnt++;
            end
            bitpos = 0;
        end else begin
            sh = {sh[6:0], spi_mosi};
            bitpos++;
            if (bitpos % 8 == 0 && bitpos / 8 <= 80) seg_log[seg_cnt % 64][bitpos/8 - 1] = sh;
        end
    end

    always @(negedge spi_sck or negedge spi_cs_n) begin
        logic [7:0] b;
        b = resp(bitpos / 8);
        spi_miso = b[7 - (bitpos % 8)];
    end

    // chip-select high time and idle-clock monitor
    int  high_cnt = 0;
    int  last_gap = 0;
    int  idle_viol = 0;
    logic prev_cs = 1'b1;
    always @(posedge clk) begin
        if (rst_n && spi_cs_n && spi_sck) idle_viol++;
        if (!spi_cs_n && prev_cs) last_gap = high_cnt;
        if (spi_cs_n) high_cnt++; else high_cnt = 0;
        prev_cs = spi_cs_n;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(5'd0, s);
            if (!s[0]) return;
        end
        chk(1'b0, "R2 busy never cleared", s, 32'h0);
    endtask

    function automatic logic [7:0] exp_menu(int i);
        case (i)
            0: return 8'h03; 1: return 8'h02; 2: return 8'h9F; 3: return 8'h01;
            4: return 8'h05; 5: return 8'h0B; 6: return 8'hD8; default: return 8'h31;
        endcase
    endfunction

    function automatic logic [1:0] exp_type(int i);
        case (i)
            0: return 2'b10; 1: return 2'b11; 2: return 2'b00; 3: return 2'b01;
            4: return 2'b00; 5: return 2'b10; 6: return 2'b11; default: return 2'b01;
        endcase
    endfunction

    function automatic logic [7:0] pat(int j, int s);
        return 8'((j * 5 + s * 17 + 1) & 255);
    endfunction

    // Runs one cycle and checks the frame, buffer and status
    task automatic run_cycle(input int idx, input int nbytes, input logic [23:0] fa,
                             input bit atomic, input bit psel, input logic [7:0] pre_op);
        int base, mseg, plen, bad, k0;
        logic [1:0] t;
        logic [7:0] e, a;
        logic [31:0] v, ctl;
        t = exp_type(idx);
        wr(5'd2, {8'h0, fa});
        if (t[0] && nbytes > 0)
            for (int w = 0; w < 16; w++)
                wr(5'(16 + w), {pat(4*w+3, idx+nbytes), pat(4*w+2, idx+nbytes),
                                pat(4*w+1, idx+nbytes), pat(4*w, idx+nbytes)});
        base = seg_cnt;
        ctl = 32'h2 | (32'(idx) << 4) | (32'(psel) << 3) | (32'(atomic) << 2);
        if (nbytes > 0) ctl = ctl | 32'h4000 | (32'(nbytes - 1) << 8);
        wr(5'd1, ctl);
        rd(5'd0, v);
        chk(v[0] == 1'b1, "R2 busy after go", v, 32'h1);
        wait_idle();
        repeat (4) @(negedge clk);
        mseg = base;
        if (atomic) begin
            chk(seg_cnt == base + 2, "R9 atomic frame count", 32'(seg_cnt - base), 32'd2);
            chk(seg_len[base % 64] == 1 && seg_log[base % 64][0] == pre_op,
                "R9 prefix frame", {24'h0, seg_log[base % 64][0]}, {24'h0, pre_op});
            chk(last_gap >= 2 * CLK_DIV, "R9 chip select gap", 32'(last_gap), 32'(2 * CLK_DIV));
            mseg = base + 1;
        end else begin
            chk(seg_cnt == base + 1, "R5 frame count", 32'(seg_cnt - base), 32'd1);
        end
        plen = 1 + (t[1] ? 3 : 0) + nbytes;
        chk(seg_len[mseg % 64] == plen, "R6 frame length", 32'(seg_len[mseg % 64]), 32'(plen));
        bad = -1;
        for (int p = 0; p < plen && p < 80; p++) begin
            if (p == 0) e = exp_menu(idx);
            else if (t[1] && p <= 3) e = fa[8*(3-p) +: 8];
            else e = t[0] ? pat(p - 1 - (t[1] ? 3 : 0), idx + nbytes) : 8'h00;
            if (bad < 0 && seg_log[mseg % 64][p] !== e) begin
                bad = p; a = seg_log[mseg % 64][p];
                chk(1'b0, $sformatf("R5/R7/R8 frame byte %0d idx %0d", p, idx), {24'h0, a}, {24'h0, e});
            end
        end
        if (bad < 0) chk(1'b1, "R5 R6 R7 frame bytes", 32'h0, 32'h0);
        if (!t[0] && nbytes > 0) begin
            k0 = 1 + (t[1] ? 3 : 0);
            bad = 0;
            for (int j = 0; j < nbytes; j++) begin
                rd(5'(16 + j / 4), v);
                if (bad == 0 && v[8*(j%4) +: 8] !== resp(k0 + j)) begin
                    bad = 1;
                    chk(1'b0, $sformatf("R8 read byte %0d", j), {24'h0, v[8*(j%4) +: 8]}, {24'h0, resp(k0 + j)});
                end
            end
            if (bad == 0) chk(1'b1, "R8 read data", 32'h0, 32'h0);
        end
        rd(5'd0, v);
        chk((v & 32'h800D) == 32'h4 || (v & 32'h800D) == 32'h8004, "R2 R3 status after cycle", v, 32'h4);
        wr(5'd0, 32'h4);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] v;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(5'd0, v);
        chk(v == 32'h0, "R1 status reset", v, 32'h0);
        rd(5'd1, v);
        chk(v == 32'h0, "R1 control reset", v, 32'h0);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 port idle", {30'h0, spi_cs_n, spi_sck}, 32'h2);

        // menu, types, prefixes
        wr(5'd4, {exp_menu(3), exp_menu(2), exp_menu(1), exp_menu(0)});
        wr(5'd5, {exp_menu(7), exp_menu(6), exp_menu(5), exp_menu(4)});
        begin
            logic [15:0] tv;
            for (int i = 0; i < 8; i++) tv[2*i +: 2] = exp_type(i);
            wr(5'd3, {16'h0, tv});
            rd(5'd3, v);
            chk(v[15:0] == tv, "R6 type register readback", v, {16'h0, tv});
        end
        wr(5'd6, 32'h0000_5006);

        // sweep: every entry x data sizes (R5 R6 R7 R8)
        for (int idx = 0; idx < 8; idx++) begin
            run_cycle(idx, 0, 24'h12_34_56 + 24'(idx * 24'h010101), 1'b0, 1'b0, 8'h0);
            run_cycle(idx, 1, 24'hA5_0F_C3 - 24'(idx), 1'b0, 1'b0, 8'h0);
            run_cycle(idx, 6, 24'h00_80_01 + 24'(idx), 1'b0, 1'b0, 8'h0);
            run_cycle(idx, 64, 24'hFE_DC_BA, 1'b0, 1'b0, 8'h0);
        end

        // R9: atomic with both prefix selections
        run_cycle(1, 1, 24'h01_02_03, 1'b1, 1'b1, 8'h50);
        run_cycle(3, 2, 24'h0, 1'b1, 1'b0, 8'h06);

        // R3: sticky flags, write-one-to-clear
        wr(5'd1, 32'h2 | (2 << 4));
        wait_idle();
        rd(5'd0, v);
        chk(v[2] == 1'b1, "R3 done set", v, 32'h4);
        wr(5'd0, 32'h0);
        rd(5'd0, v);
        chk(v[2] == 1'b1, "R3 done kept by zero write", v, 32'h4);
        wr(5'd0, 32'h4);
        rd(5'd0, v);
        chk(v[2] == 1'b0, "R3 done cleared", v, 32'h0);

        // R4: go while busy
        wr(5'd2, 32'h00_11_22);
        base = seg_cnt;
        wr(5'd1, 32'h2 | 32'h4000 | (32'd63 << 8));
        repeat (5) @(negedge clk);
        wr(5'd1, 32'h2 | (32'd2 << 4));
        rd(5'd0, v);
        chk(v[3] == 1'b1 && v[0] == 1'b1, "R4 error on go while busy", v, 32'h9);
        wait_idle();
        repeat (4) @(negedge clk);
        chk(seg_cnt == base + 1, "R4 single frame", 32'(seg_cnt - base), 32'd1);
        chk(seg_log[base % 64][0] == exp_menu(0) && seg_len[base % 64] == 68,
            "R4 first cycle intact", {24'h0, seg_log[base % 64][0]}, {24'h0, exp_menu(0)});
        wr(5'd0, 32'h4);
        rd(5'd0, v);
        chk(v[3] == 1'b1 && v[2] == 1'b0, "R3 error kept when clearing done", v, 32'h8);
        wr(5'd0, 32'h8);
        rd(5'd0, v);
        chk(v[3:0] == 4'h0, "R3 error cleared", v, 32'h0);

        // R11: base limit
        wr(5'd7, 32'h10_0000);
        wr(5'd2, 32'h0F_FFFF);
        base = seg_cnt;
        wr(5'd1, 32'h2 | (32'd0 << 4));
        rd(5'd0, v);
        chk(v[3] == 1'b1 && v[0] == 1'b0, "R11 reject flags", v, 32'h8);
        repeat (40) @(negedge clk);
        chk(seg_cnt == base && spi_cs_n == 1'b1, "R11 no SPI activity", 32'(seg_cnt - base), 32'd0);
        wr(5'd0, 32'h8);
        run_cycle(5, 0, 24'h10_0000, 1'b0, 1'b0, 8'h0);
        run_cycle(2, 1, 24'h00_0001, 1'b0, 1'b0, 8'h0);
        wr(5'd7, 32'h0);

        // R10: lock
        wr(5'd0, 32'h8000);
        rd(5'd0, v);
        chk(v[15] == 1'b1, "R10 lock reads back", v, 32'h8000);
        wr(5'd4, 32'hFFFF_FFFF);
        wr(5'd5, 32'hEEEE_EEEE);
        wr(5'd3, 32'h0000_0000);
        rd(5'd4, v);
        chk(v == {exp_menu(3), exp_menu(2), exp_menu(1), exp_menu(0)}, "R10 menu low frozen", v,
            {exp_menu(3), exp_menu(2), exp_menu(1), exp_menu(0)});
        rd(5'd5, v);
        chk(v == {exp_menu(7), exp_menu(6), exp_menu(5), exp_menu(4)}, "R10 menu high frozen", v,
            {exp_menu(7), exp_menu(6), exp_menu(5), exp_menu(4)});
        wr(5'd0, 32'h0);
        rd(5'd0, v);
        chk(v[15] == 1'b1, "R10 lock holds", v, 32'h8000);
        run_cycle(6, 3, 24'h33_44_55, 1'b0, 1'b0, 8'h0);

        chk(idle_viol == 0, "R12 clock low while deselected", 32'(idle_viol), 32'h0);

        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 run did not finish actual=0x0 expected=0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule